// File: doc/BRIEF.md
# Access Fault Status Capture and Exception Frame Builder

This block runs when a memory access fails. The failure can be a failed address translation or a bus access that reached unmapped memory. The block records a 16-bit fault status word and the faulting address. It then writes a fixed access-error exception frame onto the supervisor stack, one stack item at a time, through a simple memory write port. The frame has 18 items: fifteen fault-context items followed by a format-7 header, which holds the format/vector word, the return PC and the saved status register. The stack pointer drops by 4 for each longword and by 2 for each word. When the frame is complete, the block returns the final stack pointer together with a one-cycle done pulse.

A second fault that arrives while a frame is still being written cannot be recovered from. The block raises a sticky double-fault flag for it. Vector fetch and the rest of exception entry belong to the surrounding core.

Top module: `afault_frame_builder`

## Requirements
- R1: After reset the outputs are all low: `busy_o`, `done_o`, `wr_req_o` and `double_fault_o` are 0, and `ssw_o`, `fault_addr_o` and `sp_o` are zero.
- R2: A translation fault accepted while idle loads the status word from scratch. Bit 10 is set. Bits 6:5 hold 01 for a byte, 10 for a word and 00 for a longword, where `size_i` is 0 for byte, 1 for word and 2 for longword. Bit 8 is set for a read. Bit 2 is set for supervisor. Bit 1 is set for an instruction fetch, otherwise bit 0 is set. Every other bit is 0.
- R3: A bus fault accepted while idle clears only bits 6:5 and 2:0 of the previous status word, then rebuilds those fields as in R2. It ORs in bit 10, and it ORs in bit 8 for a read. Bit 8 is never cleared by a bus fault.
- R4: An accepted fault latches `fault_addr_i`, and `fault_addr_o` shows it from the next cycle on.
- R5: The frame is written as 18 pushes, from higher to lower addresses, in this order: eight zero longwords; the fault address as a longword, twice; three zero words; the status word; the fault address as a longword; the word {4'h7, VEC_OFFSET}; the return PC as a longword; the saved status register as a word.
- R6: Before each push the stack pointer is reduced by 4 (longword) or 2 (word). The write goes to the reduced address. A longword has byte enables 4'b1111. A word has byte enables 4'b0011 and its data right-justified with the upper 16 bits zero.
- R7: Bit 0 of `sp_i` is cleared before the first push. `done_o` pulses for one cycle after the last acknowledge. At that point `sp_o` equals the even stack pointer minus 60 and `busy_o` is low.
- R8: `wr_req_o` stays high, with address, data and enables stable, until `wr_ack_i` is seen. There is exactly one write per push.
- R9: A fault strobe of either kind while `busy_o` is high sets `double_fault_o`, which stays set until reset. The status word and fault address do not change, and the frame in progress completes unchanged.
- R10: When both strobes arrive together in idle, the translation-fault encoding of R2 is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_fault_i | input | 1 | Translation fault strobe |
| bus_fault_i | input | 1 | Unmapped bus access fault strobe |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| read_i | input | 1 | Faulting access was a read |
| super_i | input | 1 | Faulting access was supervisor |
| code_i | input | 1 | Faulting access was an instruction fetch |
| fault_addr_i | input | AW | Faulting address |
| sp_i | input | AW | Current supervisor stack pointer |
| sr_i | input | 16 | Status register to save |
| pc_i | input | AW | Return PC to save |
| wr_req_o | output | 1 | Stack write request |
| wr_addr_o | output | AW | Stack write address |
| wr_data_o | output | 32 | Stack write data, right-justified |
| wr_be_o | output | 4 | Byte enables |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | Frame being built |
| done_o | output | 1 | One-cycle pulse, frame complete |
| sp_o | output | AW | Working, then final, stack pointer |
| ssw_o | output | 16 | Captured status word |
| fault_addr_o | output | AW | Captured fault address |
| double_fault_o | output | 1 | Sticky double-fault flag |

## Verification
The assertions make two assumptions about the inputs. First, `size_i` never carries the unused code 3 in a cycle where a fault is accepted. Second, `wr_ack_i` is raised only while `wr_req_o` is high and lasts a single cycle. The bench keeps within both: it draws sizes only from the three legal codes, and its memory responder sees a pending request at the falling edge, waits zero to two extra cycles, and pulses the acknowledge once for that request.

// File: rtl/afault_pkg.sv
package afault_pkg;
  localparam int unsigned NUM_ITEMS = 18;
  localparam int unsigned IDX_W     = $clog2(NUM_ITEMS);
  localparam int unsigned DW        = 32;
  localparam int unsigned BEW       = DW / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [15:0] SSW_ATC     = 16'h0400;
  localparam logic [15:0] SSW_RD      = 16'h0100;
  localparam logic [15:0] SSW_SZ_BYTE = 16'h0020;
  localparam logic [15:0] SSW_SZ_WORD = 16'h0040;
  localparam logic [15:0] SSW_SZ_MASK = 16'h0060;
  localparam logic [15:0] SSW_TM_MASK = 16'h0007;
  localparam logic [15:0] SSW_TM_SUP  = 16'h0004;
  localparam logic [15:0] SSW_TM_CODE = 16'h0002;
  localparam logic [15:0] SSW_TM_DATA = 16'h0001;
  localparam logic [15:0] SSW_LEGAL   = SSW_ATC | SSW_RD | SSW_SZ_MASK | SSW_TM_MASK;

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_ADDR, SRC_SSW, SRC_VEC, SRC_PC, SRC_SR
  } item_src_e;

  typedef struct packed {
    item_src_e src;
    logic      is_long;
  } item_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DEC, ST_WRITE} seq_state_e;

  // Push order, highest address first
  function automatic item_t item_at(logic [IDX_W-1:0] idx);
    item_t it;
    if (idx < 5'd8)        it = '{SRC_ZERO, 1'b1};
    else if (idx < 5'd10)  it = '{SRC_ADDR, 1'b1};
    else if (idx < 5'd13)  it = '{SRC_ZERO, 1'b0};
    else if (idx == 5'd13) it = '{SRC_SSW,  1'b0};
    else if (idx == 5'd14) it = '{SRC_ADDR, 1'b1};
    else if (idx == 5'd15) it = '{SRC_VEC,  1'b0};
    else if (idx == 5'd16) it = '{SRC_PC,   1'b1};
    else                   it = '{SRC_SR,   1'b0};
    return it;
  endfunction
endpackage

// File: rtl/afault_ssw.sv
module afault_ssw
  import afault_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_xlat_i,
  input  logic          cap_bus_i,
  input  logic [1:0]    size_i,
  input  logic          read_i,
  input  logic          super_i,
  input  logic          code_i,
  input  logic [AW-1:0] addr_i,
  output logic [15:0]   ssw_o,
  output logic [AW-1:0] addr_o
);
  logic [15:0]   fields;
  logic [15:0]   ssw_q;
  logic [AW-1:0] addr_q;

  always_comb begin
    fields = SSW_ATC;
    case (size_i)
      SZ_BYTE: fields = fields | SSW_SZ_BYTE;
      SZ_WORD: fields = fields | SSW_SZ_WORD;
      default: ;
    endcase
    if (super_i) fields = fields | SSW_TM_SUP;
    fields = fields | (code_i ? SSW_TM_CODE : SSW_TM_DATA);
    if (read_i) fields = fields | SSW_RD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssw_q  <= '0;
      addr_q <= '0;
    end else if (cap_xlat_i) begin
      ssw_q  <= fields;
      addr_q <= addr_i;
    end else if (cap_bus_i) begin
      // keep unrelated bits, rebuild size and mode
      ssw_q  <= (ssw_q & ~(SSW_SZ_MASK | SSW_TM_MASK)) | fields;
      addr_q <= addr_i;
    end
  end

  assign ssw_o  = ssw_q;
  assign addr_o = addr_q;

  assert_size_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_xlat_i || cap_bus_i) |-> size_i != 2'b11);
  assert_xlat_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_xlat_i |=> ssw_q[10] && ((ssw_q & ~SSW_LEGAL) == 16'h0)
                   && ssw_q[2] == $past(super_i) && ssw_q[8] == $past(read_i));
  assert_bus_keeps_rw_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_bus_i && !cap_xlat_i && ssw_q[8]) |=> ssw_q[8] && ssw_q[10]);
  assert_addr_latch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_xlat_i || cap_bus_i) |=> addr_q == $past(addr_i));
endmodule

// File: rtl/afault_item.sv
module afault_item
  import afault_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter logic [11:0] VEC_OFFSET = 12'h008
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [15:0]      ssw_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [15:0]      sr_i,
  output logic [DW-1:0]    data_o,
  output logic [BEW-1:0]   be_o,
  output logic [2:0]       len_o
);
  item_t it;

  always_comb begin
    it = item_at(idx_i);
    case (it.src)
      SRC_ADDR: data_o = DW'(addr_i);
      SRC_SSW:  data_o = DW'(ssw_i);
      SRC_VEC:  data_o = DW'({4'h7, VEC_OFFSET});
      SRC_PC:   data_o = DW'(pc_i);
      SRC_SR:   data_o = DW'(sr_i);
      default:  data_o = '0;
    endcase
    be_o  = it.is_long ? 4'b1111 : 4'b0011;
    len_o = it.is_long ? 3'd4 : 3'd2;
  end
endmodule

// File: rtl/afault_seq.sv
module afault_seq
  import afault_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fault_any_i,
  input  logic [AW-1:0]    sp_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [15:0]      sr_i,
  input  logic [2:0]       len_i,
  input  logic             wr_ack_i,
  output logic             wr_req_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    sp_o,
  output logic [AW-1:0]    pc_o,
  output logic [15:0]      sr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             double_fault_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ITEMS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    sp_q, pc_q;
  logic [15:0]      sr_q;
  logic             done_q, dbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sp_q    <= '0;
      pc_q    <= '0;
      sr_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          sp_q    <= {sp_i[AW-1:1], 1'b0};
          pc_q    <= pc_i;
          sr_q    <= sr_i;
          idx_q   <= '0;
          state_q <= ST_DEC;
        end
        ST_DEC: begin
          sp_q    <= sp_q - AW'(len_i);
          state_q <= ST_WRITE;
        end
        ST_WRITE: if (wr_ack_i) begin
          if (idx_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_DEC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       dbl_q <= 1'b0;
    else if (fault_any_i && busy_o)    dbl_q <= 1'b1;
  end

  assign busy_o         = state_q != ST_IDLE;
  assign wr_req_o       = state_q == ST_WRITE;
  assign idx_o          = idx_q;
  assign sp_o           = sp_q;
  assign pc_o           = pc_q;
  assign sr_o           = sr_q;
  assign done_o         = done_q;
  assign double_fault_o = dbl_q;

  assert_ack_with_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_i |-> wr_req_o);
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> wr_req_o && $stable(sp_q) && $stable(idx_q));
  assert_sp_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sp_q[0]);
  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !wr_req_o && !$past(done_o));
  assert_double_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fault_any_i && busy_o) || dbl_q) |=> dbl_q);
endmodule

// File: rtl/afault_frame_builder.sv
module afault_frame_builder
  import afault_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter logic [11:0] VEC_OFFSET = 12'h008
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xlat_fault_i,
  input  logic          bus_fault_i,
  input  logic [1:0]    size_i,
  input  logic          read_i,
  input  logic          super_i,
  input  logic          code_i,
  input  logic [AW-1:0] fault_addr_i,
  input  logic [AW-1:0] sp_i,
  input  logic [15:0]   sr_i,
  input  logic [AW-1:0] pc_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic [BEW-1:0] wr_be_o,
  input  logic          wr_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] sp_o,
  output logic [15:0]   ssw_o,
  output logic [AW-1:0] fault_addr_o,
  output logic          double_fault_o
);
  logic             fault_any, start, cap_xlat, cap_bus;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    sp_w, pc_w;
  logic [15:0]      sr_w;
  logic [2:0]       len;

  assign fault_any = xlat_fault_i | bus_fault_i;
  assign start     = fault_any & ~busy_o;
  assign cap_xlat  = xlat_fault_i & ~busy_o;
  assign cap_bus   = bus_fault_i & ~xlat_fault_i & ~busy_o;

  afault_ssw #(.AW(AW)) u_ssw (
    .clk_i, .rst_ni,
    .cap_xlat_i (cap_xlat),
    .cap_bus_i  (cap_bus),
    .size_i, .read_i, .super_i, .code_i,
    .addr_i     (fault_addr_i),
    .ssw_o      (ssw_o),
    .addr_o     (fault_addr_o)
  );

  afault_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni,
    .start_i        (start),
    .fault_any_i    (fault_any),
    .sp_i, .pc_i, .sr_i,
    .len_i          (len),
    .wr_ack_i,
    .wr_req_o,
    .idx_o          (idx),
    .sp_o           (sp_w),
    .pc_o           (pc_w),
    .sr_o           (sr_w),
    .busy_o,
    .done_o,
    .double_fault_o
  );

  afault_item #(.AW(AW), .VEC_OFFSET(VEC_OFFSET)) u_item (
    .idx_i  (idx),
    .ssw_i  (ssw_o),
    .addr_i (fault_addr_o),
    .pc_i   (pc_w),
    .sr_i   (sr_w),
    .data_o (wr_data_o),
    .be_o   (wr_be_o),
    .len_o  (len)
  );

  assign wr_addr_o = sp_w;
  assign sp_o      = sp_w;

  assert_ssw_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ssw_o) && $stable(fault_addr_o));
endmodule

// File: tb/tb_afault_frame_builder.sv
module tb_afault_frame_builder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        xlat_fault_i = 0, bus_fault_i = 0, read_i = 0, super_i = 0, code_i = 0;
  logic [1:0]  size_i = 0;
  logic [31:0] fault_addr_i = 0, sp_i = 0, pc_i = 0;
  logic [15:0] sr_i = 0;
  logic        wr_req_o, wr_ack_i = 0, busy_o, done_o, double_fault_o;
  logic [31:0] wr_addr_o, wr_data_o, sp_o, fault_addr_o;
  logic [3:0]  wr_be_o;
  logic [15:0] ssw_o;

  int checks = 0, fails = 0, cycles = 0, wait_cnt = 0, rec_n = 0;
  logic [31:0] rec_addr [0:31];
  logic [31:0] rec_data [0:31];
  logic [3:0]  rec_be   [0:31];
  logic [15:0] model_ssw = 0;

  always #2 clk_i = ~clk_i;

  afault_frame_builder dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ssw_fields(logic [1:0] sz, bit rd, bit sup, bit cd);
    logic [15:0] f = 16'h0400;
    if (sz == 2'd0) f |= 16'h0020;
    if (sz == 2'd1) f |= 16'h0040;
    if (rd)  f |= 16'h0100;
    if (sup) f |= 16'h0004;
    f |= cd ? 16'h0002 : 16'h0001;
    return f;
  endfunction

  // expected frame item i: {is_long, data}
  function automatic logic [32:0] exp_item(int i, logic [31:0] a, logic [15:0] s,
                                           logic [31:0] pc, logic [15:0] sr);
    if (i < 8)   return {1'b1, 32'h0};
    if (i < 10)  return {1'b1, a};
    if (i < 13)  return {1'b0, 32'h0};
    if (i == 13) return {1'b0, 16'h0, s};
    if (i == 14) return {1'b1, a};
    if (i == 15) return {1'b0, 32'h0000_7008};
    if (i == 16) return {1'b1, pc};
    return {1'b0, 16'h0, sr};
  endfunction

  // memory responder
  initial forever begin
    @(negedge clk_i);
    cycles++;
    if (wr_ack_i) wr_ack_i = 1'b0;
    else if (wr_req_o) begin
      if (wait_cnt == 0) begin
        if (rec_n < 32) begin
          rec_addr[rec_n] = wr_addr_o;
          rec_data[rec_n] = wr_data_o;
          rec_be[rec_n]   = wr_be_o;
        end
        rec_n++;
        wr_ack_i = 1'b1;
        wait_cnt = int'($urandom % 3);
      end else wait_cnt--;
    end
  end

  // watchdog
  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run_frame(bit xl, bit bus, logic [1:0] sz, bit rd, bit sup, bit cd,
                           logic [31:0] a, logic [31:0] sp, logic [31:0] pc, logic [15:0] sr,
                           bit inject_double);
    logic [15:0] exp_s;
    logic [31:0] cur;
    int n;
    if (xl) exp_s = ssw_fields(sz, rd, sup, cd);
    else    exp_s = (model_ssw & ~16'h0067) | ssw_fields(sz, rd, sup, cd);
    model_ssw = exp_s;
    @(negedge clk_i);
    rec_n = 0;
    xlat_fault_i = xl; bus_fault_i = bus; size_i = sz; read_i = rd; super_i = sup;
    code_i = cd; fault_addr_i = a; sp_i = sp; pc_i = pc; sr_i = sr;
    @(negedge clk_i);
    xlat_fault_i = 0; bus_fault_i = 0;
    chk(busy_o == 1'b1, "R7 busy after fault", 32'(busy_o), 32'd1);
    chk(ssw_o == exp_s, xl ? "R2 status word" : "R3 status word", 32'(ssw_o), 32'(exp_s));
    chk(fault_addr_o == a, "R4 fault address", fault_addr_o, a);
    if (inject_double) begin
      repeat (5) @(negedge clk_i);
      xlat_fault_i = 1; fault_addr_i = ~a; size_i = 2'd2; read_i = ~rd;
      @(negedge clk_i);
      xlat_fault_i = 0;
      chk(double_fault_o == 1'b1, "R9 double fault flag", 32'(double_fault_o), 32'd1);
      chk(ssw_o == exp_s, "R9 status word unchanged", 32'(ssw_o), 32'(exp_s));
      chk(fault_addr_o == a, "R9 address unchanged", fault_addr_o, a);
    end
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk_i); n++; end
    chk(done_o == 1'b1, "R7 done pulse", 32'(done_o), 32'd1);
    chk(busy_o == 1'b0, "R7 idle at done", 32'(busy_o), 32'd0);
    cur = {sp[31:1], 1'b0};
    chk(sp_o == cur - 32'd60, "R7 final stack pointer", sp_o, cur - 32'd60);
    chk(rec_n == 18, "R8 one write per push", 32'(rec_n), 32'd18);
    for (int i = 0; i < 18 && i < rec_n; i++) begin
      logic [32:0] e = exp_item(i, a, exp_s, pc, sr);
      cur = cur - (e[32] ? 32'd4 : 32'd2);
      chk(rec_addr[i] == cur, "R6 push address", rec_addr[i], cur);
      chk(rec_be[i] == (e[32] ? 4'b1111 : 4'b0011), "R6 byte enables", 32'(rec_be[i]),
          e[32] ? 32'hF : 32'h3);
      chk(rec_data[i] == e[31:0], "R5 frame item", rec_data[i], e[31:0]);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R7 done one cycle", 32'(done_o), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && wr_req_o == 0 && done_o == 0 && double_fault_o == 0,
        "R1 reset controls", {busy_o, wr_req_o, done_o, double_fault_o}, 32'h0);
    chk(ssw_o == 0 && fault_addr_o == 0 && sp_o == 0, "R1 reset state", 32'(ssw_o), 32'h0);
    rst_ni = 1'b1;
    // directed: read byte supervisor data, odd stack pointer
    run_frame(1, 0, 2'd0, 1, 1, 0, 32'hDEAD_BEE0, 32'h0000_2001, 32'h0000_4000, 16'h2700, 0);
    // bus fault store word user code: bit 8 kept from previous read
    run_frame(0, 1, 2'd1, 0, 0, 1, 32'h1234_5678, 32'h0001_0000, 32'h0000_0100, 16'h0010, 0);
    chk(ssw_o[8] == 1'b1, "R3 rw bit kept on store", 32'(ssw_o[8]), 32'd1);
    // both strobes, store: translation encoding clears bit 8 (R10)
    run_frame(1, 1, 2'd2, 0, 1, 1, 32'h0BAD_F00D, 32'h0000_8000, 32'hFFFF_FFFE, 16'hFFFF, 0);
    chk(ssw_o[8] == 1'b0, "R10 translation wins", 32'(ssw_o[8]), 32'd0);
    // random frames
    for (int k = 0; k < 8; k++) begin
      bit xl = 1'($urandom);
      run_frame(xl, !xl, 2'($urandom % 3), 1'($urandom), 1'($urandom), 1'($urandom),
                $urandom, 32'h0010_0000 + ($urandom % 32'h1000), $urandom, 16'($urandom), 0);
    end
    // double fault during frame
    run_frame(1, 0, 2'd1, 1, 1, 0, 32'hCAFE_0000, 32'h0000_3000, 32'h0000_0200, 16'h2000, 1);
    chk(double_fault_o == 1'b1, "R9 double fault sticky", 32'(double_fault_o), 32'd1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(double_fault_o == 1'b0 && ssw_o == 0, "R1 reset clears flags", 32'(double_fault_o), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule